// File: doc/BRIEF.md
# Shadow Prefetch Queue Tracker

This block sits beside an x86-style processor and follows its bus without driving anything. It keeps its own copy of the processor's instruction prefetch queue. A code fetch is recognised from the bus status lines when the address is latched. The byte or bytes of that fetch are captured from the data bus when the transfer completes. The 2-bit queue status lines tell the tracker when the processor takes a byte out of its queue, when that byte begins an instruction, and when the queue is thrown away. Each removed byte is presented on the output together with an instruction-start strobe. Downstream logic can therefore follow instruction execution one byte at a time.

The processor variant is detected while the processor's own reset is held. A 16-bit-bus part pulls its active-low byte-high-enable line low during reset and an 8-bit-bus part does not. The detected variant fixes the mirror depth at 6 or 4 bytes. It also selects how fetched data is split into queue bytes, including the odd-address case where the low byte of the fetched word is a dummy that must be dropped. Decoding instructions and answering memory cycles are left to other blocks.

Top module: `prefetch_shadow`

## Requirements
- R1: After `rst_n` is low at a clock edge, `q_level` is 0, `q_bytes` is all zero, `deq_valid`, `insn_start` and `q_error` are 0, and `wide_cpu` is 0.
- R2: When `cpu_reset` falls, `wide_cpu` becomes 1 if `bhe_n` was seen low at any clock edge while `cpu_reset` was high, and 0 otherwise. It then holds until the next `cpu_reset` pulse. The mirror depth is 6 bytes when `wide_cpu` is 1 and 4 bytes when it is 0. While `cpu_reset` is high the mirror is empty.
- R3: A bus cycle starts at the clock edge where `ale` is 1, and `bus_status` is sampled there. Only the value 3'b100 (code fetch) makes the cycle add bytes to the mirror. Any other value adds nothing.
- R4: When `wide_cpu` is 0, a code fetch adds exactly one byte, `data_bus[7:0]`, whatever `addr0` and `bhe_n` are.
- R5: When `wide_cpu` is 1, a code fetch with `addr0`=0 and `bhe_n` low at the T2 edge adds two bytes: `data_bus[7:0]` first, then `data_bus[15:8]`.
- R6: When `wide_cpu` is 1, a code fetch with `addr0`=1 adds only `data_bus[15:8]`. The low byte is discarded.
- R7: `q_status` 2'b01 removes the oldest byte. One cycle later `deq_valid` is 1, `deq_byte` holds that byte and `insn_start` is 1. `q_status` 2'b11 does the same with `insn_start` at 0. 2'b00 does nothing.
- R8: `q_status` 2'b10 empties the mirror at that clock edge. A code fetch past its address edge (in T2 or T3, including the capture edge itself) when this happens adds nothing.
- R9: The edge after T2 is the first T3 edge. Data is captured at the first T3 edge where `ready` is 1. Edges in T3 with `ready` at 0 are wait states and leave the mirror unchanged.
- R10: A removal while the mirror is empty, or an enqueue beyond the selected depth, sets `q_error`. Bytes that do not fit are dropped, and `q_level` never exceeds the depth. `q_error` stays 1 until `rst_n` is low.
- R11: `q_bytes[7:0]` is the oldest byte, and each following byte occupies the next 8 bits. Bits above `q_level` bytes are zero.
- R12: A removal and a capture at the same edge are handled removal first. The byte that leaves is the one that was oldest before the edge, and the new bytes join behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per processor clock |
| rst_n | input | 1 | Synchronous active-low reset of the tracker |
| cpu_reset | input | 1 | Processor reset line, active high |
| ale | input | 1 | Address latch strobe, marks T1 |
| bus_status | input | 3 | Processor bus status, sampled in T1 |
| addr0 | input | 1 | Address bit 0, sampled in T1 |
| bhe_n | input | 1 | Active-low byte-high-enable |
| ready | input | 1 | Transfer ready, low inserts wait states |
| data_bus | input | 16 | Processor data bus |
| q_status | input | 2 | Queue status lines |
| deq_valid | output | 1 | A byte was removed last cycle |
| deq_byte | output | 8 | The removed byte |
| insn_start | output | 1 | The removed byte starts an instruction |
| q_bytes | output | 48 | Mirror contents, oldest in the low byte |
| q_level | output | 3 | Number of bytes held |
| wide_cpu | output | 1 | 16-bit-bus variant detected |
| q_error | output | 1 | Sticky underflow/overflow flag |

## Verification
The bench first runs the 8-bit variant. There it checks that the high data byte and `addr0` are ignored, which a design that reused the wide split would get wrong by enqueuing the odd byte. On the wide variant it mixes even and odd fetches. A tracker that kept the dummy byte, or put the high byte first, would show the wrong packing in `q_bytes`. It stretches a fetch with wait states, where an early capture would take the bus value too soon. It raises a flush in T2 of a fetch, so a tracker that forgot the cycle in flight would refill the mirror. It also fills the wide mirror exactly to six bytes without an error, pops and captures at the same edge, and removes from an empty queue. The narrow depth is pushed one byte past four to prove that the error stays set after a flush.

// File: rtl/fqm_pkg.sv
// Shared encodings for the shadow prefetch queue tracker.
// Assumes the processor status encodings listed in the brief.
package fqm_pkg;

    // Queue status line codes driven by the processor.
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    // Bus cycle phase seen by the tracker.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_T2   = 2'b01,
        PH_T3   = 2'b10
    } phase_e;

    // Bus status value that marks an instruction fetch.
    localparam logic [2:0] ST_CODE_FETCH = 3'b100;

endpackage

// File: rtl/fqm_variant_detect.sv
// Detects the processor variant from byte-high-enable during processor reset.
// Assumes: a 16-bit part drives bhe_n low at some edge while cpu_reset is high;
// the result is latched when cpu_reset falls and held until the next pulse.
module fqm_variant_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_reset,
    input  logic bhe_n,
    output logic wide_cpu
);

    logic cpu_reset_q;
    logic seen_low;

    // Tracks bhe_n during processor reset and latches the variant on its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_reset_q <= 1'b0;
            seen_low    <= 1'b0;
            wide_cpu    <= 1'b0;
        end else begin
            cpu_reset_q <= cpu_reset;
            if (cpu_reset && !cpu_reset_q) begin
                seen_low <= ~bhe_n;
            end else if (cpu_reset) begin
                seen_low <= seen_low | ~bhe_n;
            end
            if (!cpu_reset && cpu_reset_q) begin
                wide_cpu <= seen_low;
            end
        end
    end

    AST_VARIANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_reset_q |=> $stable(wide_cpu)); // R2

endmodule

// File: rtl/fqm_bus_tracker.sv
// Follows processor bus cycles T1..T3 and produces enqueue requests for code fetches.
// Assumes: ale marks T1, T2 follows, and T3 repeats (wait states) until ready is 1.
// Capture is combinational at the completing T3 edge; a flush in T2/T3 kills the cycle.
module fqm_bus_tracker
    import fqm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_reset,
    input  logic        ale,
    input  logic [2:0]  bus_status,
    input  logic        addr0,
    input  logic        bhe_n,
    input  logic        ready,
    input  logic [15:0] data_bus,
    input  logic        wide_cpu,
    input  logic        flush,
    output logic [1:0]  push_cnt,
    output logic [7:0]  push_b0,
    output logic [7:0]  push_b1
);

    phase_e phase;
    logic   is_code_q;
    logic   a0_q;
    logic   wide_cyc_q;
    logic   killed_q;
    logic   take;

    // Advances the bus phase and latches the per-cycle attributes.
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_reset) begin
            phase      <= PH_IDLE;
            is_code_q  <= 1'b0;
            a0_q       <= 1'b0;
            wide_cyc_q <= 1'b0;
            killed_q   <= 1'b0;
        end else if (ale) begin
            phase     <= PH_T2;
            is_code_q <= (bus_status == ST_CODE_FETCH);
            a0_q      <= addr0;
            killed_q  <= 1'b0;
        end else begin
            case (phase)
                PH_T2: begin
                    wide_cyc_q <= ~bhe_n;
                    phase      <= PH_T3;
                    if (flush) killed_q <= 1'b1;
                end
                PH_T3: begin
                    if (flush) killed_q <= 1'b1;
                    if (ready) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decides how many bytes the completing cycle contributes and which ones.
    always_comb begin
        take = (phase == PH_T3) && ready && is_code_q && !killed_q && !flush && !cpu_reset && !ale;
        if (!take)              push_cnt = 2'd0;
        else if (!wide_cpu)     push_cnt = 2'd1;
        else if (a0_q)          push_cnt = 2'd1;
        else if (wide_cyc_q)    push_cnt = 2'd2;
        else                    push_cnt = 2'd1;
        push_b0 = (wide_cpu && a0_q) ? data_bus[15:8] : data_bus[7:0];
        push_b1 = data_bus[15:8];
    end

    AST_CAPTURE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != 2'd0) |-> ready); // R9

    AST_NO_CAPTURE_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (push_cnt == 2'd0)); // R8

endmodule

// File: rtl/fqm_queue.sv
// Byte mirror of the prefetch queue, oldest byte in slot 0.
// Assumes: removal is applied before the enqueue of the same edge; depth_lim
// never shrinks below the current level (it only changes while the mirror is cleared).
module fqm_queue
    import fqm_pkg::*;
#(
    parameter int MAX_DEPTH = 6,
    parameter int LVLW      = $clog2(MAX_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic [1:0]             qs,
    input  logic [1:0]             push_cnt,
    input  logic [7:0]             push_b0,
    input  logic [7:0]             push_b1,
    input  logic [LVLW-1:0]        depth_lim,
    output logic [MAX_DEPTH*8-1:0] q_flat,
    output logic [LVLW-1:0]        count,
    output logic                   deq_valid,
    output logic [7:0]             deq_byte,
    output logic                   insn_start,
    output logic                   err
);

    logic                   do_pop;
    logic                   do_flush;
    logic                   pop_ok;
    logic [LVLW-1:0]        base;
    logic [LVLW-1:0]        room;
    logic [LVLW-1:0]        want;
    logic [LVLW-1:0]        keep;
    logic [LVLW-1:0]        count_nx;
    logic                   overflow;
    logic                   underflow;
    logic [MAX_DEPTH*8-1:0] q_nx;

    // Works out the level after this edge's removal and enqueue.
    always_comb begin
        do_pop    = (qs == QS_FIRST) || (qs == QS_NEXT);
        do_flush  = (qs == QS_FLUSH);
        pop_ok    = do_pop && (count != '0);
        underflow = do_pop && (count == '0);
        base      = pop_ok ? count - LVLW'(1) : count;
        room      = depth_lim - base;
        want      = LVLW'(push_cnt);
        overflow  = want > room;
        keep      = overflow ? room : want;
        count_nx  = base + keep;
    end

    for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_slot
        logic [7:0] moved;
        if (i + 1 < MAX_DEPTH) begin : g_mid
            assign moved = pop_ok ? q_flat[(i+1)*8 +: 8] : q_flat[i*8 +: 8];
        end else begin : g_top
            assign moved = pop_ok ? 8'h00 : q_flat[i*8 +: 8];
        end
        assign q_nx[i*8 +: 8] = (LVLW'(i) >= count_nx)             ? 8'h00   :
                                (LVLW'(i) == base)                  ? push_b0 :
                                (LVLW'(i) == base + LVLW'(1))       ? push_b1 :
                                                                      moved;
    end

    // Updates the stored bytes and level.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || do_flush) begin
            q_flat <= '0;
            count  <= '0;
        end else begin
            q_flat <= q_nx;
            count  <= count_nx;
        end
    end

    // Presents the removed byte one cycle after the queue status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deq_valid  <= 1'b0;
            deq_byte   <= 8'h00;
            insn_start <= 1'b0;
        end else begin
            deq_valid  <= pop_ok && !clear;
            deq_byte   <= (pop_ok && !clear) ? q_flat[7:0] : 8'h00;
            insn_start <= pop_ok && !clear && (qs == QS_FIRST);
        end
    end

    // Holds the sticky error until tracker reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (!clear && (underflow || overflow)) begin
            err <= 1'b1;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= depth_lim); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (qs == QS_FLUSH) |=> (count == '0)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R10

    AST_START_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        insn_start |-> deq_valid); // R7

endmodule

// File: rtl/prefetch_shadow.sv
// Top of the shadow prefetch queue tracker: variant detection, bus cycle
// tracking and the byte mirror. Assumes one clk edge per processor clock.
module prefetch_shadow
    import fqm_pkg::*;
#(
    parameter int NARROW_DEPTH = 4,
    parameter int WIDE_DEPTH   = 6,
    parameter int LVLW         = $clog2(WIDE_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_reset,
    input  logic                    ale,
    input  logic [2:0]              bus_status,
    input  logic                    addr0,
    input  logic                    bhe_n,
    input  logic                    ready,
    input  logic [15:0]             data_bus,
    input  logic [1:0]              q_status,
    output logic                    deq_valid,
    output logic [7:0]              deq_byte,
    output logic                    insn_start,
    output logic [WIDE_DEPTH*8-1:0] q_bytes,
    output logic [LVLW-1:0]         q_level,
    output logic                    wide_cpu,
    output logic                    q_error
);

    logic [1:0]      push_cnt;
    logic [7:0]      push_b0;
    logic [7:0]      push_b1;
    logic [LVLW-1:0] depth_lim;
    logic            flush;

    // Selects the mirror depth for the detected variant and decodes the flush.
    always_comb begin
        depth_lim = wide_cpu ? LVLW'(WIDE_DEPTH) : LVLW'(NARROW_DEPTH);
        flush     = (q_status == QS_FLUSH);
    end

    fqm_variant_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_reset (cpu_reset),
        .bhe_n     (bhe_n),
        .wide_cpu  (wide_cpu)
    );

    fqm_bus_tracker u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_reset  (cpu_reset),
        .ale        (ale),
        .bus_status (bus_status),
        .addr0      (addr0),
        .bhe_n      (bhe_n),
        .ready      (ready),
        .data_bus   (data_bus),
        .wide_cpu   (wide_cpu),
        .flush      (flush),
        .push_cnt   (push_cnt),
        .push_b0    (push_b0),
        .push_b1    (push_b1)
    );

    fqm_queue #(
        .MAX_DEPTH (WIDE_DEPTH),
        .LVLW      (LVLW)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cpu_reset),
        .qs         (q_status),
        .push_cnt   (push_cnt),
        .push_b0    (push_b0),
        .push_b1    (push_b1),
        .depth_lim  (depth_lim),
        .q_flat     (q_bytes),
        .count      (q_level),
        .deq_valid  (deq_valid),
        .deq_byte   (deq_byte),
        .insn_start (insn_start),
        .err        (q_error)
    );

endmodule

// File: tb/tb_prefetch_shadow.sv
`timescale 1ns/1ps
module tb_prefetch_shadow;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_reset;
    logic        ale;
    logic [2:0]  bus_status;
    logic        addr0;
    logic        bhe_n;
    logic        ready;
    logic [15:0] data_bus;
    logic [1:0]  q_status;
    logic        deq_valid;
    logic [7:0]  deq_byte;
    logic        insn_start;
    logic [47:0] q_bytes;
    logic [2:0]  q_level;
    logic        wide_cpu;
    logic        q_error;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [2:0] mid_level;

    always #10 clk = ~clk;

    prefetch_shadow dut (
        .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset), .ale(ale),
        .bus_status(bus_status), .addr0(addr0), .bhe_n(bhe_n), .ready(ready),
        .data_bus(data_bus), .q_status(q_status), .deq_valid(deq_valid),
        .deq_byte(deq_byte), .insn_start(insn_start), .q_bytes(q_bytes),
        .q_level(q_level), .wide_cpu(wide_cpu), .q_error(q_error)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tracker_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_cpu_reset(input bit bhe_low);
        @(negedge clk);
        cpu_reset = 1'b1;
        bhe_n = ~bhe_low;
        repeat (3) @(negedge clk);
        cpu_reset = 1'b0;
        bhe_n = 1'b1;
        @(negedge clk);
    endtask

    // One bus cycle: T1, T2, T3 with waits; optional queue status in T2 and T3.
    task automatic bus_cycle(input logic [2:0] st, input logic a0, input logic bhe,
                             input logic [15:0] d, input int waits,
                             input logic [1:0] qs_t2, input logic [1:0] qs_t3);
        @(negedge clk);
        ale = 1'b1; bus_status = st; addr0 = a0; bhe_n = bhe;
        @(negedge clk);
        ale = 1'b0; q_status = qs_t2;
        @(negedge clk);
        data_bus = d; ready = (waits == 0); q_status = qs_t3;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            mid_level = q_level;
            ready = (i == waits - 1);
            q_status = 2'b00;
        end
        @(negedge clk);
        ready = 1'b1; q_status = 2'b00; bus_status = 3'b111; bhe_n = 1'b1;
    endtask

    task automatic qop(input logic [1:0] code);
        @(negedge clk);
        q_status = code;
        @(negedge clk);
        q_status = 2'b00;
    endtask

    task automatic test_reset_state();
        check("R1", "level", q_level, 0);
        check("R1", "bytes", q_bytes, 0);
        check("R1", "deq_valid", deq_valid, 0);
        check("R1", "error", q_error, 0);
        check("R1", "wide", wide_cpu, 0);
    endtask

    task automatic test_narrow_fill();
        pulse_cpu_reset(1'b0);
        check("R2", "narrow detect", wide_cpu, 0);
        bus_cycle(3'b100, 1'b0, 1'b0, 16'h55A1, 0, 2'b00, 2'b00);
        bus_cycle(3'b101, 1'b0, 1'b0, 16'h00B7, 0, 2'b00, 2'b00);
        check("R3", "non-code cycle ignored", q_level, 1);
        bus_cycle(3'b100, 1'b1, 1'b0, 16'h99A2, 0, 2'b00, 2'b00);
        bus_cycle(3'b100, 1'b0, 1'b1, 16'h77A3, 0, 2'b00, 2'b00);
        check("R4", "narrow level", q_level, 3);
        check("R11", "narrow contents", q_bytes, 48'h0000_00A3_A2A1);
    endtask

    task automatic test_removals();
        qop(2'b01);
        check("R7", "first deq_valid", deq_valid, 1);
        check("R7", "first byte", deq_byte, 8'hA1);
        check("R7", "first start", insn_start, 1);
        qop(2'b11);
        check("R7", "next byte", deq_byte, 8'hA2);
        check("R7", "next start", insn_start, 0);
        check("R7", "level after removals", q_level, 1);
        check("R11", "contents after removals", q_bytes, 48'h0000_0000_00A3);
    endtask

    task automatic test_flush_and_overflow();
        qop(2'b10);
        check("R8", "flush level", q_level, 0);
        check("R8", "flush bytes", q_bytes, 0);
        for (int k = 1; k <= 4; k++)
            bus_cycle(3'b100, 1'b0, 1'b1, 16'h00B0 | 16'(k), 0, 2'b00, 2'b00);
        check("R10", "narrow full no error", q_error, 0);
        bus_cycle(3'b100, 1'b0, 1'b1, 16'h00B5, 0, 2'b00, 2'b00);
        check("R10", "overflow level capped", q_level, 4);
        check("R10", "overflow error", q_error, 1);
        check("R10", "overflow contents", q_bytes, 48'h0000_B4B3_B2B1);
        qop(2'b10);
        check("R10", "error sticky over flush", q_error, 1);
        tracker_reset();
        check("R10", "error cleared by reset", q_error, 0);
        check("R1", "wide after reset", wide_cpu, 0);
    endtask

    task automatic test_wide_fetches();
        pulse_cpu_reset(1'b1);
        check("R2", "wide detect", wide_cpu, 1);
        check("R2", "empty after cpu reset", q_level, 0);
        bus_cycle(3'b100, 1'b0, 1'b0, 16'h2211, 0, 2'b00, 2'b00);
        check("R5", "even word level", q_level, 2);
        check("R5", "even word order", q_bytes, 48'h0000_0000_2211);
        bus_cycle(3'b100, 1'b1, 1'b0, 16'h4433, 0, 2'b00, 2'b00);
        check("R6", "odd fetch level", q_level, 3);
        check("R6", "odd fetch drops dummy", q_bytes, 48'h0000_0044_2211);
    endtask

    task automatic test_wait_states();
        bus_cycle(3'b100, 1'b0, 1'b0, 16'h6655, 2, 2'b00, 2'b00);
        check("R9", "no capture during wait", mid_level, 3);
        check("R9", "capture after wait", q_level, 5);
        bus_cycle(3'b100, 1'b1, 1'b0, 16'h7700, 0, 2'b00, 2'b00);
        check("R2", "wide depth six", q_level, 6);
        check("R2", "no error at six", q_error, 0);
        check("R11", "full wide contents", q_bytes, 48'h7766_5544_2211);
    endtask

    task automatic test_pop_with_push();
        bus_cycle(3'b100, 1'b1, 1'b0, 16'h8800, 0, 2'b00, 2'b01);
        check("R12", "removed byte is old head", deq_byte, 8'h11);
        check("R12", "start strobe", insn_start, 1);
        check("R12", "level", q_level, 6);
        check("R12", "contents", q_bytes, 48'h8877_6655_4422);
        check("R12", "no error", q_error, 0);
    endtask

    task automatic test_flush_in_flight();
        bus_cycle(3'b100, 1'b0, 1'b0, 16'hCCDD, 0, 2'b10, 2'b00);
        check("R8", "in-flight fetch discarded", q_level, 0);
        check("R8", "bytes empty", q_bytes, 0);
    endtask

    task automatic test_underflow();
        qop(2'b11);
        check("R10", "no byte on empty removal", deq_valid, 0);
        check("R10", "underflow error", q_error, 1);
    endtask

    initial begin
        rst_n = 1'b0; cpu_reset = 1'b0; ale = 1'b0; bus_status = 3'b111;
        addr0 = 1'b0; bhe_n = 1'b1; ready = 1'b1; data_bus = 16'h0000;
        q_status = 2'b00; mid_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_narrow_fill();
        test_removals();
        test_flush_and_overflow();
        test_wide_fetches();
        test_wait_states();
        test_pop_with_push();
        test_flush_in_flight();
        test_underflow();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule